// File: doc/BRIEF.md
# Dead-band Load Sequencer

This block decides when new dead-band counts take effect in a complementary waveform generator. Software writes the rising-edge and falling-edge counts into two holding registers. These writes do nothing to the counts in use until software arms a load through a control byte. The control byte also carries an enable bit and a 3-bit output mode field.

Once a load is armed, the block watches the generator's input data signal. That signal is first passed through a two-flop synchroniser. The block then waits for a falling edge on it, followed by a rising edge. On that rising edge it copies both holding registers into the active count outputs in a single clock edge, and hardware clears the request bit. Software polls the request bit to learn when the transfer has happened. Delay generation and per-mode output steering sit in neighbouring blocks, which read the active counts and the mode field.

Top module: `deadband_load_seq`

## Requirements
- R1: The control byte reads back as {enable at bit 7, load request at bit 6, three zero bits at 5..3, mode at bits 2..0}. Bits 5..3 of a write are dropped.
- R2: Synchronous active-low reset clears the control byte, both active counts, the edge tracking and the synchroniser.
- R3: A control write sets the load request only if enable was already 1 before that write. A write that sets enable and the request together leaves the request at 0.
- R4: While the request is 1, the first rising data edge that follows a falling data edge seen after arming copies both holding registers into the active counts on the same clock edge.
- R5: While the request is 0, writes to the holding registers and data edges leave both active counts unchanged.
- R6: A rising data edge seen after arming but before any falling edge does not cause a load.
- R7: The request reads 0 from the clock edge that performs the transfer onward.
- R8: A control write with enable 0 clears enable and the request, discards any falling edge already seen, and leaves the active counts unchanged.
- R9: The mode codes are 000 asynchronous steering, 001 synchronous steering, 010 forward full-bridge, 011 reverse full-bridge, 100 half-bridge and 101 push-pull. Codes 110 and 111 are stored as written and drive `mode_invalid` high; every other code drives it low.
- R10: The transfer lands on the third rising clock edge after the data input rises, counting from the first edge that samples the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| rise_we | input | 1 | Rising-edge holding register write strobe |
| rise_wdata | input | CNT_W | Rising-edge holding count |
| fall_we | input | 1 | Falling-edge holding register write strobe |
| fall_wdata | input | CNT_W | Falling-edge holding count |
| data_in | input | 1 | Asynchronous generator input data |
| rise_active | output | CNT_W | Active rising-edge dead-band count |
| fall_active | output | CNT_W | Active falling-edge dead-band count |
| mode_invalid | output | 1 | Stored mode is a reserved code |

## Verification
The bench arms the request in the same write that sets enable. A design that samples the new enable would arm there and later load counts software never meant to apply. It also raises the data input before any falling edge after arming. A design that loads on any rising edge would take the counts half a period early.

Further cases are disabling while a falling edge is already recorded, and writing the holding registers while nothing is armed. A design that kept stale tracking or passed the holding values straight through would change the active counts there.

Reserved mode codes, dropped bits 5..3, and the exact three-edge synchroniser latency are each checked at the ports. A mid-sequence reset is also checked, followed by data edges that must not load.

// File: rtl/dbl_pkg.sv
// Package dbl_pkg
// Shared constants and types for the dead-band load sequencer.
// Assumes an 8-bit control byte whose enable/request bit positions are
// decoded by software, so they are fixed here rather than parameterised.
package dbl_pkg;

    localparam int CTL_W       = 8;
    localparam int CTL_EN_BIT  = 7;
    localparam int CTL_REQ_BIT = 6;
    localparam int MODE_W      = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_ASYNC_STEER = 3'b000,
        MODE_SYNC_STEER  = 3'b001,
        MODE_FWD_FULL    = 3'b010,
        MODE_REV_FULL    = 3'b011,
        MODE_HALF_BRIDGE = 3'b100,
        MODE_PUSH_PULL   = 3'b101,
        MODE_RSVD_A      = 3'b110,
        MODE_RSVD_B      = 3'b111
    } mode_e;

    function automatic logic mode_is_reserved(input mode_e m);
        return (m == MODE_RSVD_A) || (m == MODE_RSVD_B);
    endfunction

endpackage

// File: rtl/dbl_ctl_reg.sv
// Module dbl_ctl_reg
// Holds enable, load request and mode.
// Assumes load_done is a single-cycle pulse from the arm tracker.
// A control write takes priority over a hardware clear in the same cycle.
// The request may be set only when enable was already 1 before the write.
module dbl_ctl_reg
    import dbl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             load_done,
    output logic             en,
    output logic             req,
    output mode_e            mode
);

    logic unused_rsvd_bits;
    assign unused_rsvd_bits = ^wdata[5:3];

    // Update enable, request and mode from software writes and hardware clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            req  <= 1'b0;
            mode <= MODE_ASYNC_STEER;
        end else if (we) begin
            en   <= wdata[CTL_EN_BIT];
            mode <= mode_e'(wdata[MODE_W-1:0]);
            if (!wdata[CTL_EN_BIT])
                req <= 1'b0;
            else if (wdata[CTL_REQ_BIT] && en)
                req <= 1'b1;
            else if (load_done)
                req <= 1'b0;
        end else if (load_done) begin
            req <= 1'b0;
        end
    end

endmodule

// File: rtl/dbl_edge_sync.sv
// Module dbl_edge_sync
// Synchronises an asynchronous level through SYNC_STAGES flops.
// Produces one-cycle rise and fall pulses by comparing the synchronised
// level with its previous sample.
// Assumes SYNC_STAGES >= 2.
module dbl_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_ev,
    output logic fall_ev
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   level;

    assign level = chain[SYNC_STAGES-1];

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], din};
    end

    // Keep the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    assign rise_ev = level & ~prev;
    assign fall_ev = ~level & prev;

endmodule

// File: rtl/dbl_arm_track.sv
// Module dbl_arm_track
// Tracks the fall-then-rise sequence while a load is armed.
// Assumes req stays 1 until this block pulses load or software disables.
// Any cycle with req low discards a recorded falling edge.
module dbl_arm_track (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic rise_ev,
    input  logic fall_ev,
    output logic load
);

    logic fall_seen;

    assign load = req & fall_seen & rise_ev;

    // Record a falling edge once armed; clear on transfer or disarm.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fall_seen <= 1'b0;
        else if (!req || load)
            fall_seen <= 1'b0;
        else if (fall_ev)
            fall_seen <= 1'b1;
    end

endmodule

// File: rtl/dbl_active_regs.sv
// Module dbl_active_regs
// Active dead-band count pair.
// Both counts are updated together from the holding values on a load pulse
// and are held otherwise.
module dbl_active_regs #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] rise_hold,
    input  logic [CNT_W-1:0] fall_hold,
    output logic [CNT_W-1:0] rise_act,
    output logic [CNT_W-1:0] fall_act
);

    // Copy both holding values at once when a load fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_act <= '0;
            fall_act <= '0;
        end else if (load) begin
            rise_act <= rise_hold;
            fall_act <= fall_hold;
        end
    end

endmodule

// File: rtl/deadband_load_seq.sv
// Module deadband_load_seq
// Top of the dead-band load sequencer.
// Software writes holding counts and a control byte; an armed request
// transfers both counts on the first rising data edge after a falling one.
// Assumes data_in is asynchronous to clk.
module deadband_load_seq
    import dbl_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             rise_we,
    input  logic [CNT_W-1:0] rise_wdata,
    input  logic             fall_we,
    input  logic [CNT_W-1:0] fall_wdata,
    input  logic             data_in,
    output logic [CNT_W-1:0] rise_active,
    output logic [CNT_W-1:0] fall_active,
    output logic             mode_invalid
);

    localparam int PAD_W = CTL_W - 2 - MODE_W;

    logic             en;
    logic             req;
    mode_e            mode;
    logic             rise_ev;
    logic             fall_ev;
    logic             load;
    logic [CNT_W-1:0] rise_hold;
    logic [CNT_W-1:0] fall_hold;

    // Capture software writes to the holding counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_hold <= '0;
            fall_hold <= '0;
        end else begin
            if (rise_we) rise_hold <= rise_wdata;
            if (fall_we) fall_hold <= fall_wdata;
        end
    end

    dbl_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ctl_we),
        .wdata     (ctl_wdata),
        .load_done (load),
        .en        (en),
        .req       (req),
        .mode      (mode)
    );

    dbl_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (data_in),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    dbl_arm_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .load    (load)
    );

    dbl_active_regs #(.CNT_W(CNT_W)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .rise_hold (rise_hold),
        .fall_hold (fall_hold),
        .rise_act  (rise_active),
        .fall_act  (fall_active)
    );

    assign ctl_rdata    = {en, req, {PAD_W{1'b0}}, mode};
    assign mode_invalid = mode_is_reserved(mode);

endmodule

// File: rtl/dbl_load_seq_chk.sv
// Module dbl_load_seq_chk
// Port-level assertions for deadband_load_seq, attached with bind.
module dbl_load_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [7:0]       ctl_wdata,
    input logic [7:0]       ctl_rdata,
    input logic [CNT_W-1:0] rise_active,
    input logic [CNT_W-1:0] fall_active,
    input logic             mode_invalid
);

    // R1
    pad_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[5:3] == 3'b000);

    // R3
    no_arm_same_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[7] && ctl_wdata[6] && !ctl_rdata[7]) |=> !ctl_rdata[6]);

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_rdata[6]) |-> ($stable(rise_active) && $stable(fall_active)));

    // R7
    req_cleared_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rise_active) || !$stable(fall_active)) |-> !ctl_rdata[6]);

    // R8
    disable_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_wdata[7]) |=> (ctl_rdata[7:6] == 2'b00));

    // R9
    reserved_mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && (ctl_wdata[2:1] == 2'b11)) |=> mode_invalid);

endmodule

bind deadband_load_seq dbl_load_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_we       (ctl_we),
    .ctl_wdata    (ctl_wdata),
    .ctl_rdata    (ctl_rdata),
    .rise_active  (rise_active),
    .fall_active  (fall_active),
    .mode_invalid (mode_invalid)
);

// File: tb/tb_deadband_load_seq.sv
`timescale 1ns/1ps
module tb_deadband_load_seq;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_we = 1'b0;
    logic [7:0]   ctl_wdata = '0;
    logic [7:0]   ctl_rdata;
    logic         rise_we = 1'b0;
    logic [W-1:0] rise_wdata = '0;
    logic         fall_we = 1'b0;
    logic [W-1:0] fall_wdata = '0;
    logic         data_in = 1'b0;
    logic [W-1:0] rise_active;
    logic [W-1:0] fall_active;
    logic         mode_invalid;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    deadband_load_seq #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .rise_we(rise_we), .rise_wdata(rise_wdata),
        .fall_we(fall_we), .fall_wdata(fall_wdata),
        .data_in(data_in),
        .rise_active(rise_active), .fall_active(fall_active),
        .mode_invalid(mode_invalid)
    );

    typedef struct packed {
        logic       we;
        logic [7:0] wd;
        logic [7:0] hv;
        logic       din;
        logic [7:0] rd;
        logic [7:0] er;
        logic [7:0] ef;
        logic       inv;
    } step_t;

    localparam int NSTEP = 14;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 8'hC1, 8'h11, 1'b0, 8'h81, 8'h00, 8'h00, 1'b0}, // R3 en+req together: no arm
        '{1'b1, 8'hC1, 8'h11, 1'b0, 8'hC1, 8'h00, 8'h00, 1'b0}, // R3 arm with en already 1
        '{1'b0, 8'h00, 8'h11, 1'b1, 8'hC1, 8'h00, 8'h00, 1'b0}, // R6 rise before fall
        '{1'b0, 8'h00, 8'h11, 1'b0, 8'hC1, 8'h00, 8'h00, 1'b0}, // R4 fall seen
        '{1'b0, 8'h00, 8'h11, 1'b1, 8'h81, 8'h11, 8'hEE, 1'b0}, // R4 R7 load, req cleared
        '{1'b0, 8'h00, 8'h5A, 1'b0, 8'h81, 8'h11, 8'hEE, 1'b0}, // R5 hold write, idle
        '{1'b0, 8'h00, 8'h5A, 1'b1, 8'h81, 8'h11, 8'hEE, 1'b0}, // R5 edges, idle
        '{1'b1, 8'hFA, 8'h5A, 1'b1, 8'hC2, 8'h11, 8'hEE, 1'b0}, // R1 bits 5..3 dropped
        '{1'b1, 8'h00, 8'h5A, 1'b0, 8'h00, 8'h11, 8'hEE, 1'b0}, // R8 disable while armed
        '{1'b0, 8'h00, 8'h5A, 1'b1, 8'h00, 8'h11, 8'hEE, 1'b0}, // R8 no load after disable
        '{1'b1, 8'h86, 8'h5A, 1'b1, 8'h86, 8'h11, 8'hEE, 1'b1}, // R9 mode 110
        '{1'b1, 8'hC7, 8'h3C, 1'b1, 8'hC7, 8'h11, 8'hEE, 1'b1}, // R9 mode 111, armed
        '{1'b0, 8'h00, 8'h3C, 1'b0, 8'hC7, 8'h11, 8'hEE, 1'b1}, // R4 fall
        '{1'b0, 8'h00, 8'h3C, 1'b1, 8'h87, 8'h3C, 8'hC3, 1'b1}  // R4 R7 load
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic hold_write(input logic [7:0] v);
        @(negedge clk);
        rise_we = 1'b1; rise_wdata = v; fall_we = 1'b1; fall_wdata = ~v;
        @(negedge clk);
        rise_we = 1'b0; fall_we = 1'b0;
    endtask

    task automatic set_din(input logic v);
        @(negedge clk);
        data_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 ctl after reset", ctl_rdata, 8'h00);
        chk("R2 rise_active after reset", rise_active, 8'h00);
        chk("R2 fall_active after reset", fall_active, 8'h00);
        chk("R2 mode_invalid after reset", {7'd0, mode_invalid}, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            ctl_we = STEPS[i].we; ctl_wdata = STEPS[i].wd;
            rise_we = 1'b1; rise_wdata = STEPS[i].hv;
            fall_we = 1'b1; fall_wdata = ~STEPS[i].hv;
            data_in = STEPS[i].din;
            @(negedge clk);
            ctl_we = 1'b0; rise_we = 1'b0; fall_we = 1'b0;
            repeat (3) @(negedge clk);
            chk($sformatf("R1 R3 R7 R8 ctl step %0d", i), ctl_rdata, STEPS[i].rd);
            chk($sformatf("R4 R5 R6 rise_active step %0d", i), rise_active, STEPS[i].er);
            chk($sformatf("R4 R5 fall_active step %0d", i), fall_active, STEPS[i].ef);
            chk($sformatf("R9 mode_invalid step %0d", i), {7'd0, mode_invalid}, {7'd0, STEPS[i].inv});
        end

        // R6: arm while data low, rise first, no load
        hold_write(8'h44);
        set_din(1'b0);
        ctl_write(8'hC0);
        chk("R9 mode 000 not reserved", {7'd0, mode_invalid}, 8'h00);
        set_din(1'b1);
        chk("R6 rise before fall keeps active", rise_active, 8'h3C);
        chk("R6 request still armed", ctl_rdata, 8'hC0);
        set_din(1'b0);
        // R10: latency of three edges
        @(negedge clk);
        data_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 no load after two edges", rise_active, 8'h3C);
        @(negedge clk);
        chk("R10 load on third edge rise", rise_active, 8'h44);
        chk("R10 load on third edge fall", fall_active, 8'hBB);
        chk("R7 request cleared at load", ctl_rdata, 8'h80);

        // R2: reset while armed with fall seen
        ctl_write(8'hC0);
        set_din(1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R2 ctl cleared mid-sequence", ctl_rdata, 8'h00);
        chk("R2 rise_active cleared", rise_active, 8'h00);
        set_din(1'b1);
        chk("R2 no load after reset", fall_active, 8'h00);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule